// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Byte-Lane Register Window

This block is an unsigned 32x32 multiplier with a hidden 64-bit accumulator, attached beside a processor register file. Its two operands always come from two fixed processor registers, which drive the `op_a` and `op_b` inputs directly. The unit presents three 32-bit registers in a window that starts at register number 25. Register 25 is the control register. Registers 26 and 27 hold the low and high halves of the result. The processor reaches the window through byte-granular transfers, each given as a start register, a start byte and a byte count.

There are two modes. In multiply-only mode, each `tick` (one per processor instruction) takes the current operands and updates the result registers with their product, and the accumulator is kept at zero. In accumulate mode, `tick` is ignored. Each transfer that writes the control register performs one accumulate step, unless the same write clears a pending carry. A carry that comes out of bit 63 is latched in the control register, and software clears it by writing 1 to it.

Top module: `mac_unit`

## Requirements
- R1: With control bit 0 clear after any write in the same cycle, a `tick` loads {`prod_hi`,`prod_lo`} with the unsigned 64-bit product `op_a`*`op_b` on the next cycle and forces the accumulator to zero.
- R2: With control bit 0 set, `tick` leaves `prod_lo`, `prod_hi` and the accumulator unchanged.
- R3: A legal transfer that starts at register 25 with a nonzero length and leaves control bit 0 set performs one step. It adds `op_a`*`op_b` to the 64-bit accumulator, and the new sum appears in both the accumulator and {`prod_hi`,`prod_lo`}.
- R4: When an accumulate step wraps past 2^64, control bit 1 (carry) is set and stays set until it is cleared.
- R5: A control write that covers byte lane 0 with data bit 1 = 1 while carry is set clears carry and zeroes the accumulator, and no step occurs in that write. Writing 1 to bit 1 while carry is clear has no effect, and no write can set carry.
- R6: A transfer whose start register is below 25, or whose last byte lies beyond register 27 (regn*4+byte+len > 112), raises `xf_err` in the following cycle and changes no register.
- R7: A legal transfer writes only the `xf_len` bytes that begin at window offset (regn-25)*4+byte. Window byte k is taken from `xf_data[8k+7:8k]`. Offsets 0-3 are register 25, offsets 4-7 are register 26 (`prod_lo`), and offsets 8-11 are register 27 (`prod_hi`).
- R8: After reset all three registers and the accumulator are zero, the unit is in multiply-only mode and `xf_err` is low.
- R9: Control bits 31:2 always read zero. Control bit 0 changes only when a legal transfer covers window byte 0, and it then takes `xf_data[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One pulse per processor instruction |
| op_a | input | 32 | First operand register value |
| op_b | input | 32 | Second operand register value |
| xf_valid | input | 1 | Transfer into the window this cycle |
| xf_regn | input | 5 | Start register number of the transfer |
| xf_byte | input | 2 | Start byte inside the start register |
| xf_len | input | 4 | Number of bytes transferred |
| xf_data | input | 96 | Window-aligned write data, byte k at bits 8k+7:8k |
| xf_err | output | 1 | Previous cycle carried an illegal transfer |
| mode_q | output | 32 | Control register (bit 0 accumulate, bit 1 carry) |
| prod_lo | output | 32 | Result register, low half |
| prod_hi | output | 32 | Result register, high half |

## Verification
Several kinds of operand pattern are used: random operands, all-ones operands, and zero or one operands. Random operands confirm the full 64-bit product. All-ones operands drive the accumulator across 2^64 so that the carry latch and its write-one clear can be observed. Zero or one operands separate an accumulated sum from a plain product. The transfers cover every start register from 23 to 28, every start byte and every length. Because of this, in-window partial-lane writes, transfers that touch the control register, and out-of-window errors are all compared against a byte-level model, with ticks mixed in both modes.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DW        = 32;
  localparam int BPR       = DW / 8;
  localparam int FIRST_REG = 25;
  localparam int NREG      = 3;
  localparam int WIN_BYTES = NREG * BPR;
  localparam int REGW      = 5;
  localparam int BYTW      = 2;
  localparam int LENW      = 4;

  localparam int CTL_IDX = 0;
  localparam int LO_IDX  = 1;
  localparam int HI_IDX  = 2;

  localparam int BIT_ACC   = 0;
  localparam int BIT_CARRY = 1;

  typedef logic [DW-1:0]   word_t;
  typedef logic [2*DW-1:0] dword_t;

  typedef struct packed {
    logic legal;
    logic ctl_wr;
    logic [WIN_BYTES-1:0] lane;
  } xf_dec_t;
endpackage

// File: rtl/mac_lane_decode.sv
module mac_lane_decode
  import mac_pkg::*;
#(
  parameter int P_FIRST = FIRST_REG,
  parameter int P_NREG  = NREG,
  parameter int P_BPR   = BPR,
  parameter int P_REGW  = REGW,
  parameter int P_BYTW  = BYTW,
  parameter int P_LENW  = LENW
) (
  input  logic              valid,
  input  logic [P_REGW-1:0] regn,
  input  logic [P_BYTW-1:0] start_byte,
  input  logic [P_LENW-1:0] len,
  output logic              legal,
  output logic              ctl_wr,
  output logic [P_NREG*P_BPR-1:0] lane
);
  localparam int NB    = P_NREG * P_BPR;
  localparam int AW    = P_REGW + P_BYTW + 2;
  localparam int LIMIT = (P_FIRST + P_NREG) * P_BPR;
  localparam int BASE  = P_FIRST * P_BPR;

  logic [AW-1:0] abs_start;
  logic [AW-1:0] abs_end;
  logic          in_low;
  logic          in_high;

  always_comb begin
    abs_start = AW'(regn) * AW'(P_BPR) + AW'(start_byte);
    abs_end   = abs_start + AW'(len);
    in_low    = (int'(regn) >= P_FIRST);
    in_high   = (int'(abs_end) <= LIMIT);
    legal     = valid && in_low && in_high;
    ctl_wr    = legal && (int'(regn) == P_FIRST) && (len != '0);
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_comb begin
      lane[k] = legal
             && (int'(abs_start) <= BASE + k)
             && (int'(abs_end) > BASE + k);
    end
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int P_DW = DW
) (
  input  logic [P_DW-1:0]   a,
  input  logic [P_DW-1:0]   b,
  input  logic [2*P_DW-1:0] acc,
  output logic [2*P_DW-1:0] product,
  output logic [2*P_DW-1:0] sum,
  output logic              wrap
);
  logic [2*P_DW:0] wide_sum;

  always_comb begin
    product  = (2*P_DW)'(a) * (2*P_DW)'(b);
    wide_sum = {1'b0, acc} + {1'b0, product};
    sum      = wide_sum[2*P_DW-1:0];
    wrap     = wide_sum[2*P_DW];
  end
endmodule

// File: rtl/mac_mode_ctrl.sv
module mac_mode_ctrl
  import mac_pkg::*;
(
  input  logic legal,
  input  logic ctl_wr,
  input  logic lane0,
  input  logic wr_acc_bit,
  input  logic wr_carry_bit,
  input  logic tick,
  input  logic acc_mode_q,
  input  logic carry_q,
  input  logic wrap,
  output logic acc_mode_d,
  output logic carry_d,
  output logic do_clear,
  output logic do_step,
  output logic do_mul
);
  always_comb begin
    acc_mode_d = (legal && lane0) ? wr_acc_bit : acc_mode_q;
    do_clear   = ctl_wr && lane0 && wr_carry_bit && carry_q;
    do_step    = ctl_wr && acc_mode_d && !do_clear;
    do_mul     = tick && !acc_mode_d;
    if (do_clear) begin
      carry_d = 1'b0;
    end else if (do_step) begin
      carry_d = carry_q | wrap;
    end else begin
      carry_d = carry_q;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        xf_valid,
  input  logic [4:0]  xf_regn,
  input  logic [1:0]  xf_byte,
  input  logic [3:0]  xf_len,
  input  logic [95:0] xf_data,
  output logic        xf_err,
  output logic [31:0] mode_q,
  output logic [31:0] prod_lo,
  output logic [31:0] prod_hi
);
  xf_dec_t dec;
  word_t   lo_q, hi_q, lo_d, hi_d;
  dword_t  acc_q, acc_d;
  logic    acc_mode_q, acc_mode_d;
  logic    carry_q, carry_d;
  logic    err_q, err_d;
  logic    reg_en;
  dword_t  product, sum;
  logic    wrap;
  logic    do_clear, do_step, do_mul;

  mac_lane_decode u_dec (
    .valid      (xf_valid),
    .regn       (xf_regn),
    .start_byte (xf_byte),
    .len        (xf_len),
    .legal      (dec.legal),
    .ctl_wr     (dec.ctl_wr),
    .lane       (dec.lane)
  );

  mac_arith u_arith (
    .a       (op_a),
    .b       (op_b),
    .acc     (acc_q),
    .product (product),
    .sum     (sum),
    .wrap    (wrap)
  );

  mac_mode_ctrl u_ctrl (
    .legal        (dec.legal),
    .ctl_wr       (dec.ctl_wr),
    .lane0        (dec.lane[0]),
    .wr_acc_bit   (xf_data[BIT_ACC]),
    .wr_carry_bit (xf_data[BIT_CARRY]),
    .tick         (tick),
    .acc_mode_q   (acc_mode_q),
    .carry_q      (carry_q),
    .wrap         (wrap),
    .acc_mode_d   (acc_mode_d),
    .carry_d      (carry_d),
    .do_clear     (do_clear),
    .do_step      (do_step),
    .do_mul       (do_mul)
  );

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    acc_d = acc_q;
    for (int k = 0; k < BPR; k++) begin
      if (dec.lane[LO_IDX*BPR + k]) lo_d[8*k +: 8] = xf_data[8*(LO_IDX*BPR + k) +: 8];
      if (dec.lane[HI_IDX*BPR + k]) hi_d[8*k +: 8] = xf_data[8*(HI_IDX*BPR + k) +: 8];
    end
    if (do_clear) begin
      acc_d = '0;
    end else if (do_step) begin
      acc_d = sum;
      lo_d  = sum[DW-1:0];
      hi_d  = sum[2*DW-1:DW];
    end
    if (do_mul) begin
      acc_d = '0;
      lo_d  = product[DW-1:0];
      hi_d  = product[2*DW-1:DW];
    end
    err_d  = xf_valid && !dec.legal;
    reg_en = xf_valid || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      hi_q       <= '0;
      acc_q      <= '0;
      acc_mode_q <= 1'b0;
      carry_q    <= 1'b0;
    end else if (reg_en) begin
      lo_q       <= lo_d;
      hi_q       <= hi_d;
      acc_q      <= acc_d;
      acc_mode_q <= acc_mode_d;
      carry_q    <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign xf_err  = err_q;
  assign prod_lo = lo_q;
  assign prod_hi = hi_q;
  assign mode_q  = {30'd0, carry_q, acc_mode_q};
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        xf_valid,
  input logic [4:0]  xf_regn,
  input logic [1:0]  xf_byte,
  input logic [3:0]  xf_len,
  input logic [95:0] xf_data,
  input logic        xf_err,
  input logic [31:0] mode_q,
  input logic [31:0] prod_lo,
  input logic [31:0] prod_hi
);
  logic [7:0]  span_end;
  logic        bad_xf;
  logic [63:0] full_prod;

  always_comb begin
    span_end  = {1'b0, xf_regn, 2'b00} + {6'd0, xf_byte} + {4'd0, xf_len};
    bad_xf    = xf_valid && ((xf_regn < 5'd25) || (span_end > 8'd112));
    full_prod = {32'd0, op_a} * {32'd0, op_b};
  end

  a_r6_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bad_xf |=> xf_err);

  a_r6_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_xf && !tick) |=> ($stable(mode_q) && $stable(prod_lo) && $stable(prod_hi)));

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !xf_valid && !mode_q[0]) |=> ({prod_hi, prod_lo} == $past(full_prod)));

  a_r2_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !xf_valid && mode_q[0]) |=> ($stable(prod_lo) && $stable(prod_hi)));

  a_r4_carry_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q[1]) |-> $past(xf_valid));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_xf && xf_valid && xf_regn == 5'd25 && xf_byte == 2'd0 && xf_len != 4'd0
     && mode_q[1] && xf_data[1]) |=> !mode_q[1]);

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[31:2] == 30'd0);
endmodule

bind mac_unit mac_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .op_a     (op_a),
  .op_b     (op_b),
  .xf_valid (xf_valid),
  .xf_regn  (xf_regn),
  .xf_byte  (xf_byte),
  .xf_len   (xf_len),
  .xf_data  (xf_data),
  .xf_err   (xf_err),
  .mode_q   (mode_q),
  .prod_lo  (prod_lo),
  .prod_hi  (prod_hi)
);

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [31:0] op_a, op_b;
  logic        xf_valid;
  logic [4:0]  xf_regn;
  logic [1:0]  xf_byte;
  logic [3:0]  xf_len;
  logic [95:0] xf_data;
  logic        xf_err;
  logic [31:0] mode_q, prod_lo, prod_hi;

  int n_cmp;
  int n_bad;

  logic        m_acc_mode, m_carry, m_err;
  logic [63:0] m_acc, m_res;

  mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .op_a(op_a), .op_b(op_b),
    .xf_valid(xf_valid), .xf_regn(xf_regn), .xf_byte(xf_byte),
    .xf_len(xf_len), .xf_data(xf_data), .xf_err(xf_err),
    .mode_q(mode_q), .prod_lo(prod_lo), .prod_hi(prod_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] mul64(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r;
    r = 64'd0;
    for (int i = 0; i < 32; i++) if (b[i]) r = r + ({32'd0, a} << i);
    return r;
  endfunction

  task automatic model_step();
    int   s, e;
    logic legal, lane0, ctl, clr, step, mode_next;
    logic [64:0] t;
    s     = int'(xf_regn) * 4 + int'(xf_byte);
    e     = s + int'(xf_len);
    legal = xf_valid && (xf_regn >= 5'd25) && (e <= 112);
    m_err = xf_valid && !legal;
    lane0 = legal && (s == 100) && (xf_len != 0);
    ctl   = legal && (xf_regn == 5'd25) && (xf_len != 0);
    if (legal)
      for (int k = 4; k < 12; k++)
        if ((100 + k >= s) && (100 + k < e)) m_res[8*(k-4) +: 8] = xf_data[8*k +: 8];
    mode_next = lane0 ? xf_data[0] : m_acc_mode;
    clr  = ctl && lane0 && xf_data[1] && m_carry;
    step = ctl && mode_next && !clr;
    if (clr) begin
      m_carry = 1'b0;
      m_acc   = 64'd0;
    end else if (step) begin
      t       = {1'b0, m_acc} + {1'b0, mul64(op_a, op_b)};
      m_acc   = t[63:0];
      m_res   = t[63:0];
      if (t[64]) m_carry = 1'b1;
    end
    m_acc_mode = mode_next;
    if (tick && !mode_next) begin
      m_res = mul64(op_a, op_b);
      m_acc = 64'd0;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, {32'd0, mode_q}, {62'd0, m_carry, m_acc_mode}, "mode");
    chk(tag, {prod_hi, prod_lo}, m_res, "result");
    chk("R6", {63'd0, xf_err}, {63'd0, m_err}, "err");
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    tick     = 1'b0;
    xf_valid = 1'b0;
  endtask

  task automatic put(input logic [4:0] r, input logic [1:0] b, input logic [3:0] l,
                     input logic [95:0] d, input logic tk, input string tag);
    xf_valid = 1'b1; xf_regn = r; xf_byte = b; xf_len = l; xf_data = d; tick = tk;
    cyc(tag);
  endtask

  task automatic set_ops(input logic [31:0] a, input logic [31:0] b);
    op_a = a; op_b = b;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    n_cmp = 0; n_bad = 0;
    seed = $urandom(32'h5eed_0c1a);
    rst_n = 1'b0; tick = 1'b0; op_a = '0; op_b = '0;
    xf_valid = 1'b0; xf_regn = '0; xf_byte = '0; xf_len = '0; xf_data = '0;
    m_acc_mode = 0; m_carry = 0; m_err = 0; m_acc = 0; m_res = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R8");

    // R1: multiply-only ticks with random and edge operands
    set_ops(32'hFFFF_FFFF, 32'hFFFF_FFFF); tick = 1; cyc("R1");
    set_ops(32'h1234_5678, 32'h9ABC_DEF0); tick = 1; cyc("R1");
    set_ops(32'd0, 32'hDEAD_BEEF);         tick = 1; cyc("R1");
    // R7: partial lane write into result registers, then no tick holds it
    put(5'd26, 2'd1, 4'd5, {12{8'hA5}}, 1'b0, "R7");
    cyc("R7");
    // R6: illegal transfers leave all state
    put(5'd24, 2'd3, 4'd2, {12{8'h3C}}, 1'b0, "R6");
    put(5'd27, 2'd2, 4'd3, {12{8'h3C}}, 1'b0, "R6");
    put(5'd28, 2'd0, 4'd1, {12{8'h3C}}, 1'b0, "R6");
    // R9: writing to control bytes 1..3 does not change bit 0
    put(5'd25, 2'd1, 4'd3, {96{1'b1}}, 1'b0, "R9");
    // R3: enter accumulate mode, first step from zero accumulator
    set_ops(32'd7, 32'd6);
    put(5'd25, 2'd0, 4'd1, 96'h1, 1'b0, "R3");
    set_ops(32'd1, 32'd1);
    put(5'd25, 2'd0, 4'd1, 96'h1, 1'b0, "R3");
    // R2: ticks ignored in accumulate mode
    set_ops(32'hAAAA_0000, 32'h5555);
    tick = 1; cyc("R2");
    tick = 1; cyc("R2");
    // R4: all-ones steps wrap the accumulator
    set_ops(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    put(5'd25, 2'd0, 4'd1, 96'h1, 1'b0, "R4");
    put(5'd25, 2'd0, 4'd1, 96'h1, 1'b0, "R4");
    put(5'd25, 2'd0, 4'd1, 96'h1, 1'b0, "R4");
    // R5: clear by writing one, no step in that write
    put(5'd25, 2'd0, 4'd1, 96'h3, 1'b0, "R5");
    set_ops(32'd3, 32'd5);
    put(5'd25, 2'd0, 4'd1, 96'h3, 1'b0, "R5");
    // back to multiply mode with simultaneous tick
    put(5'd25, 2'd0, 4'd4, 96'h0, 1'b1, "R1");

    // mixed random stimulus against the bench model
    for (int i = 0; i < 3000; i++) begin
      op_a = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
      op_b = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
      tick = ($urandom % 2 == 0);
      xf_valid = ($urandom % 3 == 0);
      xf_regn = 5'(23 + ($urandom % 6));
      xf_byte = 2'($urandom % 4);
      xf_len = 4'($urandom % 13);
      xf_data = {$urandom, $urandom, $urandom};
      if ($urandom % 2 == 0) begin
        xf_regn = 5'd25; xf_byte = 2'd0; xf_len = 4'd1;
        xf_data[0] = ($urandom % 4 != 0);
      end
      cyc("R7");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule